// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block owns one bank of pins and decides, pin by pin, whether each pad is driven by general-purpose I/O logic or by one of four peripheral function groups (A, B, C, D). Software reaches it through a single-cycle word register port. Most control bits are changed with write-one-to-set and write-one-to-clear register pairs, so a write touches only the pins whose data bits are 1. Matching status registers read the resulting state back.

Under GPIO ownership the block produces the pad output level and output enable. These come from an output-enable bit and an output-data bit, plus an optional open-drain (multi-drive) mode in which a 1 releases the pad. It also presents pull-up, pull-down and Schmitt-trigger-disable controls to the pad cell, and an interrupt-enable mask to the interrupt logic that sits outside this block. Under peripheral ownership, two plain read-write select registers pick which group's output and enable reach the pad. Pin n of a global numbering lives in bank n/32 at bit position n mod 32.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every pin is GPIO-owned (ownership status all ones), pull-ups are all enabled, and output enable, output data, pull-down, multi-drive, both select registers, Schmitt control and interrupt enable are all zero; pad_oe is all zero.
- R2: A write to GPIO_TAKE (address 0) sets ownership for each 1 bit, and a write to GPIO_GIVE (address 1) clears it. Other pins keep their value. OWN_STAT (address 2) reads 1 for GPIO-owned pins.
- R3: The pairs OE (set 3, clear 4, status 5), DOUT (set 6, clear 7, status 8), PULLUP (set 10, clear 11, status 12), PULLDN (set 13, clear 14, status 15) and OPENDRN (set 16, clear 17, status 18) change only the bits written as 1. PULLUP and PULLDN state drive pad_pu and pad_pd directly.
- R4: A pin not owned by GPIO takes its pad output and enable from the peripheral group given by {SEL_HI bit, SEL_LO bit}: 00 selects A, 01 selects B, 10 selects C, 11 selects D.
- R5: SEL_LO (address 19), SEL_HI (address 20) and SCHMITT_OFF (address 21) are plain read-write registers that read back what was written. A 1 in SCHMITT_OFF asserts pad_st_off for that pin.
- R6: A GPIO-owned pin without multi-drive drives pad_out from its DOUT bit and pad_oe from its OE bit.
- R7: A GPIO-owned pin in multi-drive mode drives pad_out low. pad_oe is its OE bit while DOUT is 0 and is deasserted while DOUT is 1.
- R8: A pull-down set is ignored for pins whose pull-up is on, and a pull-up set is ignored for pins whose pull-down is on, so both pulls are never on together.
- R9: PIN_LEVEL (address 9) reads the live pad_in value.
- R10: Reads of write-only and unmapped addresses return zero. Writes to status and unmapped addresses change no state.
- R11: IRQ_ON (address 22) sets and IRQ_OFF (address 23) clears per-pin interrupt enables. The state appears on irq_en and reads at IRQ_STAT (address 24).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | 32 | Live pad levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pad_pd | output | 32 | Pad pull-down enable |
| pad_st_off | output | 32 | Pad Schmitt trigger disable |
| irq_en | output | 32 | Per-pin interrupt enable |
| periph_a_out | input | 32 | Group A output levels |
| periph_a_oe | input | 32 | Group A output enables |
| periph_b_out | input | 32 | Group B output levels |
| periph_b_oe | input | 32 | Group B output enables |
| periph_c_out | input | 32 | Group C output levels |
| periph_c_oe | input | 32 | Group C output enables |
| periph_d_out | input | 32 | Group D output levels |
| periph_d_oe | input | 32 | Group D output enables |

## Verification
The bench places four adjacent pins on the four distinct select codes at once. A design that swaps the roles of the two select registers would route B and C crosswise, and the pad pattern shows it. It mixes multi-drive pins holding 1 and 0 next to a push-pull pin, which catches a design that drives the pad high in open-drain mode or releases a low. It tries to turn on a pull while the opposite pull is on, both before and after freeing the pin. It also reads write-only and unmapped addresses and writes to a status address, which exposes decode aliasing that would leak or corrupt state.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_GPIO_TAKE = 5'd0;
  localparam logic [ADDR_W-1:0] A_GPIO_GIVE = 5'd1;
  localparam logic [ADDR_W-1:0] A_OWN_STAT  = 5'd2;
  localparam logic [ADDR_W-1:0] A_OE_SET    = 5'd3;
  localparam logic [ADDR_W-1:0] A_OE_CLR    = 5'd4;
  localparam logic [ADDR_W-1:0] A_OE_STAT   = 5'd5;
  localparam logic [ADDR_W-1:0] A_DO_SET    = 5'd6;
  localparam logic [ADDR_W-1:0] A_DO_CLR    = 5'd7;
  localparam logic [ADDR_W-1:0] A_DO_STAT   = 5'd8;
  localparam logic [ADDR_W-1:0] A_PIN_LEVEL = 5'd9;
  localparam logic [ADDR_W-1:0] A_PU_SET    = 5'd10;
  localparam logic [ADDR_W-1:0] A_PU_CLR    = 5'd11;
  localparam logic [ADDR_W-1:0] A_PU_STAT   = 5'd12;
  localparam logic [ADDR_W-1:0] A_PD_SET    = 5'd13;
  localparam logic [ADDR_W-1:0] A_PD_CLR    = 5'd14;
  localparam logic [ADDR_W-1:0] A_PD_STAT   = 5'd15;
  localparam logic [ADDR_W-1:0] A_MD_SET    = 5'd16;
  localparam logic [ADDR_W-1:0] A_MD_CLR    = 5'd17;
  localparam logic [ADDR_W-1:0] A_MD_STAT   = 5'd18;
  localparam logic [ADDR_W-1:0] A_SEL_LO    = 5'd19;
  localparam logic [ADDR_W-1:0] A_SEL_HI    = 5'd20;
  localparam logic [ADDR_W-1:0] A_ST_OFF    = 5'd21;
  localparam logic [ADDR_W-1:0] A_IRQ_ON    = 5'd22;
  localparam logic [ADDR_W-1:0] A_IRQ_OFF   = 5'd23;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT  = 5'd24;

  typedef enum logic [1:0] {
    FN_A = 2'b00,
    FN_B = 2'b01,
    FN_C = 2'b10,
    FN_D = 2'b11
  } fn_sel_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NPINS-1:0]      wdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      rdata,
  output logic [NPINS-1:0]      own_q,
  output logic [NPINS-1:0]      oe_q,
  output logic [NPINS-1:0]      dout_q,
  output logic [NPINS-1:0]      pu_q,
  output logic [NPINS-1:0]      pd_q,
  output logic [NPINS-1:0]      md_q,
  output logic [NPINS-1:0]      sel_lo_q,
  output logic [NPINS-1:0]      sel_hi_q,
  output logic [NPINS-1:0]      st_off_q,
  output logic [NPINS-1:0]      irq_q
);
  localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};
  localparam logic [NPINS-1:0] ALL_ZERO = {NPINS{1'b0}};

  logic [NPINS-1:0] own_d, oe_d, dout_d, pu_d, pd_d, md_d;
  logic [NPINS-1:0] sel_lo_d, sel_hi_d, st_off_d, irq_d;

  // next-state: set/clear pairs touch only the written 1 bits
  always_comb begin
    own_d    = own_q;
    oe_d     = oe_q;
    dout_d   = dout_q;
    pu_d     = pu_q;
    pd_d     = pd_q;
    md_d     = md_q;
    sel_lo_d = sel_lo_q;
    sel_hi_d = sel_hi_q;
    st_off_d = st_off_q;
    irq_d    = irq_q;
    case (addr)
      A_GPIO_TAKE: own_d    = own_q | wdata;
      A_GPIO_GIVE: own_d    = own_q & ~wdata;
      A_OE_SET:    oe_d     = oe_q | wdata;
      A_OE_CLR:    oe_d     = oe_q & ~wdata;
      A_DO_SET:    dout_d   = dout_q | wdata;
      A_DO_CLR:    dout_d   = dout_q & ~wdata;
      A_PU_SET:    pu_d     = pu_q | (wdata & ~pd_q);
      A_PU_CLR:    pu_d     = pu_q & ~wdata;
      A_PD_SET:    pd_d     = pd_q | (wdata & ~pu_q);
      A_PD_CLR:    pd_d     = pd_q & ~wdata;
      A_MD_SET:    md_d     = md_q | wdata;
      A_MD_CLR:    md_d     = md_q & ~wdata;
      A_SEL_LO:    sel_lo_d = wdata;
      A_SEL_HI:    sel_hi_d = wdata;
      A_ST_OFF:    st_off_d = wdata;
      A_IRQ_ON:    irq_d    = irq_q | wdata;
      A_IRQ_OFF:   irq_d    = irq_q & ~wdata;
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= ALL_ONES;
      oe_q     <= ALL_ZERO;
      dout_q   <= ALL_ZERO;
      pu_q     <= ALL_ONES;
      pd_q     <= ALL_ZERO;
      md_q     <= ALL_ZERO;
      sel_lo_q <= ALL_ZERO;
      sel_hi_q <= ALL_ZERO;
      st_off_q <= ALL_ZERO;
      irq_q    <= ALL_ZERO;
    end else if (we) begin
      own_q    <= own_d;
      oe_q     <= oe_d;
      dout_q   <= dout_d;
      pu_q     <= pu_d;
      pd_q     <= pd_d;
      md_q     <= md_d;
      sel_lo_q <= sel_lo_d;
      sel_hi_q <= sel_hi_d;
      st_off_q <= st_off_d;
      irq_q    <= irq_d;
    end
  end

  // read mux: write-only and unmapped words return zero
  always_comb begin
    case (addr)
      A_OWN_STAT:  rdata = own_q;
      A_OE_STAT:   rdata = oe_q;
      A_DO_STAT:   rdata = dout_q;
      A_PIN_LEVEL: rdata = pad_in;
      A_PU_STAT:   rdata = pu_q;
      A_PD_STAT:   rdata = pd_q;
      A_MD_STAT:   rdata = md_q;
      A_SEL_LO:    rdata = sel_lo_q;
      A_SEL_HI:    rdata = sel_hi_q;
      A_ST_OFF:    rdata = st_off_q;
      A_IRQ_STAT:  rdata = irq_q;
      default:     rdata = ALL_ZERO;
    endcase
  end

  p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_q & pd_q) == ALL_ZERO);

  p_pd_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_PD_SET) |=> ((pd_q & $past(pu_q)) == ($past(pd_q) & $past(pu_q))));

  p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_GPIO_TAKE) |=> (own_q == ($past(own_q) | $past(wdata))));

  p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_OE_CLR) |=> ((oe_q & $past(wdata)) == ALL_ZERO));

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(sel_lo_q) && $stable(sel_hi_q)));

  p_status_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_OE_STAT) |=> $stable(oe_q));
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NFN   = 4
) (
  input  logic [NPINS-1:0]          own,
  input  logic [NPINS-1:0]          oe,
  input  logic [NPINS-1:0]          dout,
  input  logic [NPINS-1:0]          md,
  input  logic [NPINS-1:0]          sel_lo,
  input  logic [NPINS-1:0]          sel_hi,
  input  logic [NFN-1:0][NPINS-1:0] fn_out,
  input  logic [NFN-1:0][NPINS-1:0] fn_oe,
  output logic [NPINS-1:0]          pad_out,
  output logic [NPINS-1:0]          pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    fn_sel_e fsel;
    logic    gp_out, gp_oe, pf_out, pf_oe;

    assign fsel = fn_sel_e'({sel_hi[i], sel_lo[i]});

    // open-drain: a 1 releases the pad, a 0 pulls low
    assign gp_out = dout[i] & ~md[i];
    assign gp_oe  = oe[i] & ~(md[i] & dout[i]);

    always_comb begin
      case (fsel)
        FN_A:    begin pf_out = fn_out[0][i]; pf_oe = fn_oe[0][i]; end
        FN_B:    begin pf_out = fn_out[1][i]; pf_oe = fn_oe[1][i]; end
        FN_C:    begin pf_out = fn_out[2][i]; pf_oe = fn_oe[2][i]; end
        default: begin pf_out = fn_out[3][i]; pf_oe = fn_oe[3][i]; end
      endcase
    end

    assign pad_out[i] = own[i] ? gp_out : pf_out;
    assign pad_oe[i]  = own[i] ? gp_oe  : pf_oe;
  end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  output logic [NPINS-1:0]  pad_st_off,
  output logic [NPINS-1:0]  irq_en,
  input  logic [NPINS-1:0]  periph_a_out,
  input  logic [NPINS-1:0]  periph_a_oe,
  input  logic [NPINS-1:0]  periph_b_out,
  input  logic [NPINS-1:0]  periph_b_oe,
  input  logic [NPINS-1:0]  periph_c_out,
  input  logic [NPINS-1:0]  periph_c_oe,
  input  logic [NPINS-1:0]  periph_d_out,
  input  logic [NPINS-1:0]  periph_d_oe
);
  localparam int NFN = 4;

  logic [NPINS-1:0] own, oe, dout, md, sel_lo, sel_hi;
  logic [NFN-1:0][NPINS-1:0] fn_out, fn_oe;

  assign fn_out = {periph_d_out, periph_c_out, periph_b_out, periph_a_out};
  assign fn_oe  = {periph_d_oe,  periph_c_oe,  periph_b_oe,  periph_a_oe};

  pinmux_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pad_in   (pad_in),
    .rdata    (reg_rdata),
    .own_q    (own),
    .oe_q     (oe),
    .dout_q   (dout),
    .pu_q     (pad_pu),
    .pd_q     (pad_pd),
    .md_q     (md),
    .sel_lo_q (sel_lo),
    .sel_hi_q (sel_hi),
    .st_off_q (pad_st_off),
    .irq_q    (irq_en)
  );

  pinmux_route #(.NPINS(NPINS), .NFN(NFN)) u_route (
    .own     (own),
    .oe      (oe),
    .dout    (dout),
    .md      (md),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .fn_out  (fn_out),
    .fn_oe   (fn_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  p_gpio_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own & ~oe & pad_oe) == '0);

  p_md_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own & md & pad_out) == '0 && (own & md & dout & pad_oe) == '0);
endmodule

// File: tb/test_pinmux_bank.sv
`timescale 1ns/1ps
module test_pinmux_bank;
  import pinmux_pkg::*;

  logic        clk, rst_n, reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, pad_in;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_off, irq_en;
  logic [31:0] pa_o, pa_e, pb_o, pb_e, pc_o, pc_e, pd_o, pd_e;

  int n_chk = 0;
  int n_bad = 0;

  pinmux_bank i_pinmux_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_st_off(pad_st_off), .irq_en(irq_en),
    .periph_a_out(pa_o), .periph_a_oe(pa_e), .periph_b_out(pb_o), .periph_b_oe(pb_e),
    .periph_c_out(pc_o), .periph_c_oe(pc_e), .periph_d_out(pd_o), .periph_d_oe(pd_e)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_OWN_STAT, v); chk("R1 own", v, 32'hFFFF_FFFF);
    rd(A_PU_STAT, v);  chk("R1 pu", v, 32'hFFFF_FFFF);
    rd(A_OE_STAT, v);  chk("R1 oe", v, 32'h0);
    rd(A_PD_STAT, v);  chk("R1 pd", v, 32'h0);
    rd(A_SEL_HI, v);   chk("R1 selhi", v, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_gpio_drive;
    logic [31:0] v;
    wr(A_OE_SET, 32'h0000_00F0);
    wr(A_DO_SET, 32'h0000_0030);
    #1 chk("R6 pad_out", pad_out, 32'h30);
    chk("R6 pad_oe", pad_oe, 32'hF0);
    wr(A_DO_CLR, 32'h0000_0010);
    wr(A_OE_CLR, 32'h0000_0080);
    rd(A_OE_STAT, v); chk("R3 oe pair", v, 32'h70);
    rd(A_DO_STAT, v); chk("R3 dout pair", v, 32'h20);
  endtask

  task automatic t_mux;
    logic [31:0] v;
    pa_o = 32'h1; pb_o = 32'h2; pc_o = 32'h0; pd_o = 32'h8;
    pa_e = '1;    pb_e = '0;    pc_e = '1;    pd_e = '1;
    wr(A_SEL_LO, 32'h0000_000A);
    wr(A_SEL_HI, 32'h0000_000C);
    wr(A_GPIO_GIVE, 32'h0000_000F);
    #1 chk("R4 pad_out A/B/C/D", pad_out, 32'h2B);
    chk("R4 pad_oe A/B/C/D", pad_oe, 32'h7D);
    wr(A_GPIO_TAKE, 32'h0000_0001);
    rd(A_OWN_STAT, v); chk("R2 own", v, 32'hFFFF_FFF1);
    #1 chk("R2 pad_out back to gpio", pad_out, 32'h2A);
    chk("R2 pad_oe back to gpio", pad_oe, 32'h7C);
  endtask

  task automatic t_rw;
    logic [31:0] v;
    rd(A_SEL_LO, v); chk("R5 sel_lo", v, 32'h0A);
    wr(A_ST_OFF, 32'hDEAD_BEEF);
    rd(A_ST_OFF, v); chk("R5 schmitt rb", v, 32'hDEAD_BEEF);
    chk("R5 pad_st_off", pad_st_off, 32'hDEAD_BEEF);
  endtask

  task automatic t_md;
    logic [31:0] v;
    wr(A_MD_SET, 32'h0000_0060);
    #1 chk("R7 pad_oe", pad_oe, 32'h5C);
    chk("R7 pad_out", pad_out, 32'h0A);
    rd(A_MD_STAT, v); chk("R3 md pair", v, 32'h60);
  endtask

  task automatic t_pull;
    wr(A_PD_SET, 32'h0000_00FF);
    #1 chk("R8 pd rejected", pad_pd, 32'h0);
    wr(A_PU_CLR, 32'h0000_000F);
    wr(A_PD_SET, 32'h0000_00FF);
    #1 chk("R8 pd accepted", pad_pd, 32'h0F);
    wr(A_PU_SET, 32'h0000_00FF);
    #1 chk("R8 pu rejected", pad_pu, 32'hFFFF_FFF0);
    wr(A_PD_CLR, 32'h0000_0001);
    #1 chk("R3 pd clear", pad_pd, 32'h0E);
  endtask

  task automatic t_level;
    logic [31:0] v;
    pad_in = 32'h1234_5678;
    rd(A_PIN_LEVEL, v); chk("R9 level", v, 32'h1234_5678);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    rd(A_OE_SET, v);   chk("R10 wo read", v, 32'h0);
    rd(5'd31, v);      chk("R10 unmapped read", v, 32'h0);
    wr(A_OE_STAT, 32'hFFFF_FFFF);
    wr(5'd30, 32'hFFFF_FFFF);
    rd(A_OE_STAT, v);  chk("R10 status write ignored", v, 32'h70);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_IRQ_ON, 32'h0000_0F00);
    wr(A_IRQ_OFF, 32'h0000_0300);
    #1 chk("R11 irq_en", irq_en, 32'h0C00);
    rd(A_IRQ_STAT, v); chk("R11 irq stat", v, 32'h0C00);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pad_in = '0;
    pa_o = '0; pa_e = '0; pb_o = '0; pb_e = '0;
    pc_o = '0; pc_e = '0; pd_o = '0; pd_e = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_gpio_drive;
    t_mux;
    t_rw;
    t_md;
    t_pull;
    t_level;
    t_zero;
    t_irq;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule